// File: doc/BRIEF.md
# Z80 Memory Decoder with ROM Banking

This block watches the bus cycles of an 8-bit Z80-style processor and turns them into chip selects and strobes. It drives two active-low memory enables: one for the code ROM and one for the parameter SRAM. Two more active-low strobes serve register addresses. One clocks an external output latch when the processor writes. The other enables an external input buffer onto the data bus when the processor reads.

The code ROM holds 128 KB and the processor sees it through a 32 KB window at the bottom of the address space. A 2-bit bank register selects which 32 KB block is visible. Software loads it with an I/O write to port 0x00, and the two register bits drive the ROM's two top address lines. For memory cycles, the block also drives WAIT_n low for one clock. SRAM cycles always get this wait state. ROM cycles get it only when a configuration input asks for it.

Every output is registered. An output reflects the bus inputs sampled at the previous rising clock edge. Reset is synchronous and active high.

Top module: `zdec_top`

## Requirements
- R1: While `rst` is sampled high, every enable and strobe goes high on the next clock, `wait_n` goes high, and `rom_bank` goes to 0.
- R2: A memory cycle (`mreq_n` low) to addresses 0x0000–0x7FFF drives `rom_cs_n` low on the clock after it is sampled, for both reads and writes.
- R3: A memory cycle to addresses 0x8000–0x9FFF drives `ram_cs_n` low on the clock after it is sampled.
- R4: A memory write (`wr_n` low) to 0xF000 drives `olat_clk_n` low for as long as the write is sampled. A read of 0xF000 leaves it high.
- R5: A memory read (`rd_n` low) of 0xF001 drives `ibuf_oe_n` low. A write to 0xF001 leaves it high.
- R6: While `mreq_n` is high, all four enables stay high. Unmapped addresses (for example 0xA000 or 0xFFFF) never assert any enable.
- R7: At most one of `rom_cs_n`, `ram_cs_n`, `olat_clk_n` and `ibuf_oe_n` is low in any cycle.
- R8: An I/O write (`iorq_n` and `wr_n` low) with `addr[7:0]` = 0x00 loads `bank_wdata` into `rom_bank` on the next clock. An I/O write to any other port leaves `rom_bank` unchanged. A memory write to address 0x0000 also leaves it unchanged.
- R9: With `ws_rom` = 0, a ROM cycle leaves `wait_n` high.
- R10: With `ws_rom` = 1, a ROM cycle drives `wait_n` low for exactly one clock. This is the clock after the first sample of `mreq_n` low, following a sample of it high.
- R11: An SRAM cycle drives `wait_n` low for exactly one clock, as in R10, whatever the value of `ws_rom`.
- R12: Register-address cycles, unmapped cycles and cycles with `mreq_n` high never drive `wait_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bank_wdata | input | 2 | Low data bus bits, captured on a bank-port write |
| ws_rom | input | 1 | 1 = insert a wait state on ROM cycles |
| rom_cs_n | output | 1 | Code ROM enable, active low |
| ram_cs_n | output | 1 | Parameter SRAM enable, active low |
| olat_clk_n | output | 1 | Output latch clock, active low |
| ibuf_oe_n | output | 1 | Input buffer output enable, active low |
| rom_bank | output | 2 | ROM high address lines (A16, A15) |
| wait_n | output | 1 | Wait request to the processor, active low |

## Verification
The hardest case is showing that the wait state lasts exactly one clock. It is tied to the falling edge of `mreq_n`, not to its level. A cycle held low for two or more clocks must therefore show the wait in the first clock only. Each vector in the bench is preceded by an idle clock with `mreq_n` high, so that a fresh falling edge is guaranteed. The vector is then held for a second clock, to check that `wait_n` has returned high while the enables are still valid. For the bank register, the bench runs three cycles back to back: a write to port 0, a write to a different port, and a memory write to address 0. This shows that only the first cycle changes `rom_bank`.

// File: rtl/zdec_pkg.sv
package zdec_pkg;
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_ROM  = 3'd1,
    RG_RAM  = 3'd2,
    RG_OREG = 3'd3,
    RG_IREG = 3'd4
  } region_e;
endpackage

// File: rtl/zdec_region.sv
module zdec_region
  import zdec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ROM_WIN   = 32'h8000,
  parameter int RAM_BASE  = 32'h8000,
  parameter int RAM_SIZE  = 32'h2000,
  parameter int OREG_ADDR = 32'hF000,
  parameter int IREG_ADDR = 32'hF001
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam logic [ADDR_W:0]   ROM_END  = (ADDR_W+1)'(ROM_WIN);
  localparam logic [ADDR_W:0]   RAM_LO   = (ADDR_W+1)'(RAM_BASE);
  localparam logic [ADDR_W:0]   RAM_HI   = (ADDR_W+1)'(RAM_BASE + RAM_SIZE);
  localparam logic [ADDR_W-1:0] OREG_A   = ADDR_W'(OREG_ADDR);
  localparam logic [ADDR_W-1:0] IREG_A   = ADDR_W'(IREG_ADDR);

  logic [ADDR_W:0] addr_x;
  assign addr_x = {1'b0, addr};

  always_comb begin
    region = RG_NONE;
    if (addr_x < ROM_END)                          region = RG_ROM;
    else if (addr_x >= RAM_LO && addr_x < RAM_HI)  region = RG_RAM;
    else if (addr == OREG_A)                       region = RG_OREG;
    else if (addr == IREG_A)                       region = RG_IREG;
  end
endmodule

// File: rtl/zdec_bank.sv
module zdec_bank #(
  parameter int PORT_W    = 8,
  parameter int BANK_W    = 2,
  parameter int BANK_PORT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic [PORT_W-1:0] port,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] bank
);
  localparam logic [PORT_W-1:0] SEL = PORT_W'(BANK_PORT);

  logic load;
  assign load = !iorq_n && !wr_n && (port == SEL);

  always_ff @(posedge clk) begin
    if (rst)       bank <= '0;
    else if (load) bank <= wdata;
  end

  // R8
  other_port_keeps_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (!iorq_n && !wr_n && port != SEL) |=> $stable(bank));

  // R8
  iorq_high_keeps_bank_chk: assert property (@(posedge clk) disable iff (rst)
    iorq_n |=> $stable(bank));
endmodule

// File: rtl/zdec_wait.sv
module zdec_wait (
  input  logic clk,
  input  logic rst,
  input  logic mreq_n,
  input  logic need_ws,
  output logic wait_n
);
  logic mreq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mreq_q <= 1'b1;
      wait_n <= 1'b1;
    end else begin
      mreq_q <= mreq_n;
      wait_n <= !(mreq_q && !mreq_n && need_ws);
    end
  end

  // R10
  wait_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    !wait_n |=> wait_n);

  // R10
  wait_follows_request_chk: assert property (@(posedge clk) disable iff (rst)
    !wait_n |-> !$past(mreq_n));
endmodule

// File: rtl/zdec_top.sv
module zdec_top
  import zdec_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PORT_W    = 8,
  parameter int BANK_W    = 2,
  parameter int BANK_PORT = 0,
  parameter int ROM_WIN   = 32'h8000,
  parameter int RAM_BASE  = 32'h8000,
  parameter int RAM_SIZE  = 32'h2000,
  parameter int OREG_ADDR = 32'hF000,
  parameter int IREG_ADDR = 32'hF001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BANK_W-1:0] bank_wdata,
  input  logic              ws_rom,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              olat_clk_n,
  output logic              ibuf_oe_n,
  output logic [BANK_W-1:0] rom_bank,
  output logic              wait_n
);
  region_e region;
  logic    mem;
  logic    need_ws;

  zdec_region #(
    .ADDR_W(ADDR_W), .ROM_WIN(ROM_WIN), .RAM_BASE(RAM_BASE),
    .RAM_SIZE(RAM_SIZE), .OREG_ADDR(OREG_ADDR), .IREG_ADDR(IREG_ADDR)
  ) u_region (
    .addr   (addr),
    .region (region)
  );

  zdec_bank #(
    .PORT_W(PORT_W), .BANK_W(BANK_W), .BANK_PORT(BANK_PORT)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .iorq_n (iorq_n),
    .wr_n   (wr_n),
    .port   (addr[PORT_W-1:0]),
    .wdata  (bank_wdata),
    .bank   (rom_bank)
  );

  assign mem     = !mreq_n;
  assign need_ws = (region == RG_RAM) || (region == RG_ROM && ws_rom);

  zdec_wait u_wait (
    .clk     (clk),
    .rst     (rst),
    .mreq_n  (mreq_n),
    .need_ws (need_ws),
    .wait_n  (wait_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_cs_n   <= 1'b1;
      ram_cs_n   <= 1'b1;
      olat_clk_n <= 1'b1;
      ibuf_oe_n  <= 1'b1;
    end else begin
      rom_cs_n   <= !(mem && region == RG_ROM);
      ram_cs_n   <= !(mem && region == RG_RAM);
      olat_clk_n <= !(mem && !wr_n && region == RG_OREG);
      ibuf_oe_n  <= !(mem && !rd_n && region == RG_IREG);
    end
  end

  // R7
  single_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~rom_cs_n, ~ram_cs_n, ~olat_clk_n, ~ibuf_oe_n}) <= 1);

  // R6
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mreq_n |=> (rom_cs_n && ram_cs_n && olat_clk_n && ibuf_oe_n));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (rom_bank == '0 && wait_n && rom_cs_n && ram_cs_n && olat_clk_n && ibuf_oe_n));
endmodule

// File: tb/zdec_top_test.sv
`timescale 1ns/1ps
module zdec_top_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] addr;
  logic        mreq_n, iorq_n, rd_n, wr_n, ws_rom;
  logic [1:0]  bank_wdata;
  logic        rom_cs_n, ram_cs_n, olat_clk_n, ibuf_oe_n, wait_n;
  logic [1:0]  rom_bank;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  zdec_top uut (
    .clk(clk), .rst(rst), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .bank_wdata(bank_wdata), .ws_rom(ws_rom),
    .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .olat_clk_n(olat_clk_n),
    .ibuf_oe_n(ibuf_oe_n), .rom_bank(rom_bank), .wait_n(wait_n)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        mreq_n;
    logic        rd_n;
    logic        wr_n;
    logic        cfg;
    logic [15:0] addr;
    logic [3:0]  en;    // expected {rom, ram, olat, ibuf}, active low
    logic        wt;    // expected wait_n in first access clock
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd9,  1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 4'b0111, 1'b1}, // R2 R9 ROM, no wait
    '{4'd10, 1'b0, 1'b0, 1'b1, 1'b1, 16'h7FFF, 4'b0111, 1'b0}, // R2 R10 ROM top, wait
    '{4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 16'h4000, 4'b0111, 1'b1}, // R2 ROM write
    '{4'd11, 1'b0, 1'b0, 1'b1, 1'b0, 16'h8000, 4'b1011, 1'b0}, // R3 R11 SRAM base
    '{4'd11, 1'b0, 1'b1, 1'b0, 1'b1, 16'h9FFF, 4'b1011, 1'b0}, // R3 R11 SRAM top
    '{4'd6,  1'b0, 1'b0, 1'b1, 1'b1, 16'hA000, 4'b1111, 1'b1}, // R6 R12 unmapped
    '{4'd6,  1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, 4'b1111, 1'b1}, // R6 R12 unmapped
    '{4'd4,  1'b0, 1'b1, 1'b0, 1'b1, 16'hF000, 4'b1101, 1'b1}, // R4 R12 latch write
    '{4'd4,  1'b0, 1'b0, 1'b1, 1'b1, 16'hF000, 4'b1111, 1'b1}, // R4 latch read ignored
    '{4'd5,  1'b0, 1'b0, 1'b1, 1'b1, 16'hF001, 4'b1110, 1'b1}, // R5 R12 buffer read
    '{4'd5,  1'b0, 1'b1, 1'b0, 1'b1, 16'hF001, 4'b1111, 1'b1}, // R5 buffer write ignored
    '{4'd6,  1'b1, 1'b0, 1'b1, 1'b1, 16'h0000, 4'b1111, 1'b1}, // R6 mreq high, ROM addr
    '{4'd6,  1'b1, 1'b0, 1'b1, 1'b1, 16'h8000, 4'b1111, 1'b1}  // R6 mreq high, SRAM addr
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    rst = 1'b1; addr = '0; mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    ws_rom = 1'b0; bank_wdata = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk({rom_cs_n, ram_cs_n, olat_clk_n, ibuf_oe_n, wait_n} == 5'b11111, "R1 outputs",
        {rom_cs_n, ram_cs_n, olat_clk_n, ibuf_oe_n, wait_n}, 5'b11111);
    chk(rom_bank == 2'd0, "R1 bank", rom_bank, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      idle();
      @(negedge clk);
      mreq_n = VECS[i].mreq_n; rd_n = VECS[i].rd_n; wr_n = VECS[i].wr_n;
      ws_rom = VECS[i].cfg; addr = VECS[i].addr;
      @(posedge clk);
      @(negedge clk);
      chk({rom_cs_n, ram_cs_n, olat_clk_n, ibuf_oe_n} == VECS[i].en,
          $sformatf("R%0d enables v%0d", VECS[i].req, i),
          {rom_cs_n, ram_cs_n, olat_clk_n, ibuf_oe_n}, VECS[i].en);
      chk(wait_n == VECS[i].wt, $sformatf("R%0d wait first v%0d", VECS[i].req, i),
          wait_n, VECS[i].wt);
      // R7 at most one enable low
      chk($countones(~{rom_cs_n, ram_cs_n, olat_clk_n, ibuf_oe_n}) <= 1,
          $sformatf("R7 v%0d", i), {rom_cs_n, ram_cs_n, olat_clk_n, ibuf_oe_n}, 4'hF);
      @(posedge clk);
      @(negedge clk);
      // R10 R11 wait lasts exactly one clock
      chk(wait_n == 1'b1, $sformatf("R10 wait second v%0d", i), wait_n, 1);
      chk({rom_cs_n, ram_cs_n, olat_clk_n, ibuf_oe_n} == VECS[i].en,
          $sformatf("R%0d enables held v%0d", VECS[i].req, i),
          {rom_cs_n, ram_cs_n, olat_clk_n, ibuf_oe_n}, VECS[i].en);
    end

    // R8 bank register
    idle();
    @(negedge clk);
    addr = 16'h0000; iorq_n = 1'b0; wr_n = 1'b0; bank_wdata = 2'd3;
    @(posedge clk);
    @(negedge clk);
    chk(rom_bank == 2'd3, "R8 port 0 load", rom_bank, 3);
    addr = 16'h0005; bank_wdata = 2'd1;
    @(posedge clk);
    @(negedge clk);
    chk(rom_bank == 2'd3, "R8 other port ignored", rom_bank, 3);
    iorq_n = 1'b1; mreq_n = 1'b0; addr = 16'h0000; bank_wdata = 2'd2;
    @(posedge clk);
    @(negedge clk);
    chk(rom_bank == 2'd3, "R8 memory write ignored", rom_bank, 3);
    mreq_n = 1'b1; wr_n = 1'b1; iorq_n = 1'b0; addr = 16'h0000; bank_wdata = 2'd1;
    @(posedge clk);
    @(negedge clk);
    chk(rom_bank == 2'd3, "R8 io read ignored", rom_bank, 3);
    wr_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(rom_bank == 2'd1, "R8 port 0 reload", rom_bank, 1);
    iorq_n = 1'b1; wr_n = 1'b1;

    // R1 reset returns bank to 0 and clears an active enable
    @(negedge clk);
    mreq_n = 1'b0; rd_n = 1'b0; addr = 16'h8000;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(rom_bank == 2'd0, "R1 bank after reset", rom_bank, 0);
    chk(ram_cs_n == 1'b1, "R1 enable after reset", ram_cs_n, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule